// File: doc/BRIEF.md
# Ring Buffer Ownership Sequencer

The sequencer steps through a circular table of code-buffer descriptors that a host and a playback engine share. Each descriptor carries a one-bit ownership flag and a count of the fragments that make up the buffer. The flag is the only hand-off between the two sides. The host refills a buffer and clears the flag to give the buffer away. The sequencer sets the flag again once it has consumed the buffer.

On every field or frame start the block reads the descriptor under its table pointer. If the flag shows fresh data, the block sends that buffer's fragments to the decoder one handshake at a time. It then writes the flag back to "consumed", pulses an interrupt, records which buffer finished and moves the pointer on. If the host has not yet returned that descriptor, the block plays the most recent valid buffer again. It does not stall and it does not jump ahead, so the decoder always gets a field. Until some buffer has been valid there is nothing to replay, and a field start with no ready buffer leaves the block idle.

Host software and descriptor memory sit outside the block. The descriptor read port is combinational: the block presents an index and samples the flag and the count in the same cycle.

Top module: `ring_own_seq`

## Requirements
- R1: After synchronous active-low reset the block has no fragment valid and no interrupt. The completed-buffer register is 0, the table pointer is 0 and there is no replay history.
- R2: In the cycle after a field-start strobe is seen in idle, `desc_rd_en` is high for exactly one cycle and `desc_rd_idx` equals the table pointer.
- R3: When the sampled flag is 0 (buffer ready), fragments 0 through count-1 are offered in ascending order, with `frag_buf` set to the buffer index. One fragment is accepted per cycle in which `frag_valid` and `frag_ready` are both high. While `frag_ready` is low the offered fragment holds.
- R4: After the last fragment of a ready buffer, one cycle follows in which `desc_done_en` writes flag value 1 to that descriptor and `irq` pulses for one cycle. In the next cycle `irq_buf_idx` holds that index and the pointer has advanced by one.
- R5: The pointer wraps from entry NUM_DESC-1 to entry 0.
- R6: When the sampled flag is 1 and a buffer has been valid before, the last valid buffer is replayed with its recorded fragment count. A replay makes no descriptor write, raises no interrupt and leaves the pointer where it is.
- R7: When the sampled flag is 1 and no buffer has ever been valid, no fragment, write or interrupt follows.
- R8: A field-start strobe that arrives while a buffer is being read, issued or completed is ignored.
- R9: A ready buffer with a fragment count of 0 issues no fragment but still gets its descriptor write and interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_start | input | 1 | Field/frame boundary strobe |
| desc_rd_en | output | 1 | Descriptor read strobe |
| desc_rd_idx | output | IDX_W | Descriptor index being read (table pointer) |
| desc_rd_status | input | 1 | Ownership flag of the read descriptor (0 = ready, 1 = consumed) |
| desc_rd_cnt | input | FRAG_W | Fragment count of the read descriptor |
| desc_done_en | output | 1 | Write strobe that sets a descriptor's flag to 1 |
| desc_done_idx | output | IDX_W | Descriptor index being marked consumed |
| frag_valid | output | 1 | Fragment offered to the decoder |
| frag_ready | input | 1 | Decoder accepts the offered fragment |
| frag_buf | output | IDX_W | Buffer index of the offered fragment |
| frag_idx | output | FRAG_W | Fragment index within the buffer |
| irq | output | 1 | One-cycle completion interrupt |
| irq_buf_idx | output | IDX_W | Index of the most recently completed buffer |

## Verification
The bench targets the replay path. One case is a field in which the host has refilled a later entry but not the one under the pointer. A design that skipped ahead would play the later buffer, and a design that advanced on replay would lose its place in the table. It also drives a field start before any buffer has been valid; a wrong design would issue stale fragments there. The pointer wrap, a zero-length buffer and a 15-fragment buffer with alternating ready test the count boundaries. An early or late completion, or a missing interrupt, shows up as a fragment-count or write-count mismatch. A second field start during a stalled transfer and a reset in mid-transfer check that neither a stray strobe nor leftover history starts a field.

// File: rtl/ring_own_pkg.sv
// Shared types for the ring buffer ownership sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ring_own_pkg;

    // Sequencer phases: waiting, descriptor read, fragment streaming, completion.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_ISSUE = 2'd2,
        SEQ_DONE  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/ring_own_ptr.sv
// Table pointer for the descriptor ring: advances by one per completed
// buffer and wraps after the last entry.
// Assumes: NUM_DESC >= 2; advance is a single-cycle strobe.
module ring_own_ptr #(
    parameter int NUM_DESC = 4,
    localparam int IDX_W = $clog2(NUM_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

    generate
        if (NUM_DESC == (1 << IDX_W)) begin : g_pow2
            // Power-of-two ring: natural binary overflow wraps the pointer.
            always_ff @(posedge clk) begin
                if (!rst_n)       ptr <= '0;
                else if (advance) ptr <= ptr + 1'b1;
            end
        end else begin : g_any
            // Arbitrary ring size: explicit compare against the last entry.
            always_ff @(posedge clk) begin
                if (!rst_n)       ptr <= '0;
                else if (advance) ptr <= (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
            end
        end
    endgenerate

    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && ptr == LAST_IDX) |=> (ptr == '0));

endmodule

// File: rtl/ring_own_hist.sv
// Replay history: remembers the index and fragment count of the last buffer
// that was found ready, and whether any buffer has been ready since reset.
// Assumes: capture is a single-cycle strobe from the descriptor read phase.
module ring_own_hist #(
    parameter int IDX_W  = 2,
    parameter int FRAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [FRAG_W-1:0] cap_cnt,
    output logic              have_valid,
    output logic [IDX_W-1:0]  last_idx,
    output logic [FRAG_W-1:0] last_cnt
);

    // Record the most recent ready buffer; reset forgets all history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_valid <= 1'b0;
            last_idx   <= '0;
            last_cnt   <= '0;
        end else if (capture) begin
            have_valid <= 1'b1;
            last_idx   <= cap_idx;
            last_cnt   <= cap_cnt;
        end
    end

    assert_hist_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        have_valid |=> have_valid);

endmodule

// File: rtl/ring_own_frag.sv
// Fragment issuer: after a start strobe, offers fragment indices 0..cnt-1
// of one buffer, advancing on each valid/ready handshake; done marks the
// final accepted fragment.
// Assumes: start only while inactive and with cnt != 0.
module ring_own_frag #(
    parameter int IDX_W  = 2,
    parameter int FRAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_buf,
    input  logic [FRAG_W-1:0] start_cnt,
    input  logic              frag_ready,
    output logic              frag_valid,
    output logic [IDX_W-1:0]  frag_buf,
    output logic [FRAG_W-1:0] frag_idx,
    output logic              done
);

    logic [FRAG_W-1:0] last_frag;
    logic              accept;

    // Handshake and end-of-buffer detection.
    always_comb begin
        accept = frag_valid && frag_ready;
        done   = accept && (frag_idx == last_frag);
    end

    // Load a new buffer on start, step the index on each accepted fragment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frag_valid <= 1'b0;
            frag_buf   <= '0;
            frag_idx   <= '0;
            last_frag  <= '0;
        end else if (start) begin
            frag_valid <= 1'b1;
            frag_buf   <= start_buf;
            frag_idx   <= '0;
            last_frag  <= start_cnt - 1'b1;
        end else if (done) begin
            frag_valid <= 1'b0;
        end else if (accept) begin
            frag_idx   <= frag_idx + 1'b1;
        end
    end

    assert_frag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && !frag_ready) |=> (frag_valid && $stable(frag_idx) && $stable(frag_buf)));

    assert_frag_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !done) |=> (frag_valid && frag_idx == $past(frag_idx) + 1'b1));

    assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !frag_valid);

endmodule

// File: rtl/ring_own_seq.sv
// Ring buffer ownership sequencer (top). On each field start, reads the
// descriptor under the table pointer; a ready buffer (flag 0) is streamed,
// marked consumed (flag 1) and signalled by a one-cycle interrupt; a
// consumed flag replays the last ready buffer without write or interrupt.
// Assumes: descriptor read data is valid combinationally in the read cycle.
module ring_own_seq
    import ring_own_pkg::*;
#(
    parameter int NUM_DESC = 4,
    parameter int FRAG_W   = 4,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    output logic              desc_rd_en,
    output logic [IDX_W-1:0]  desc_rd_idx,
    input  logic              desc_rd_status,
    input  logic [FRAG_W-1:0] desc_rd_cnt,
    output logic              desc_done_en,
    output logic [IDX_W-1:0]  desc_done_idx,
    output logic              frag_valid,
    input  logic              frag_ready,
    output logic [IDX_W-1:0]  frag_buf,
    output logic [FRAG_W-1:0] frag_idx,
    output logic              irq,
    output logic [IDX_W-1:0]  irq_buf_idx
);

    seq_state_t        state, state_nx;
    logic              replay_q, replay_nx;
    logic [IDX_W-1:0]  cur_buf;
    logic [IDX_W-1:0]  ptr;
    logic              have_valid;
    logic [IDX_W-1:0]  last_idx;
    logic [FRAG_W-1:0] last_cnt;
    logic              capture;
    logic              iss_start;
    logic [IDX_W-1:0]  iss_buf;
    logic [FRAG_W-1:0] iss_cnt;
    logic              iss_done;
    logic              is_read, buf_ready;

    ring_own_ptr #(.NUM_DESC(NUM_DESC)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (desc_done_en),
        .ptr     (ptr)
    );

    ring_own_hist #(.IDX_W(IDX_W), .FRAG_W(FRAG_W)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .cap_idx    (ptr),
        .cap_cnt    (desc_rd_cnt),
        .have_valid (have_valid),
        .last_idx   (last_idx),
        .last_cnt   (last_cnt)
    );

    ring_own_frag #(.IDX_W(IDX_W), .FRAG_W(FRAG_W)) u_frag (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (iss_start),
        .start_buf  (iss_buf),
        .start_cnt  (iss_cnt),
        .frag_ready (frag_ready),
        .frag_valid (frag_valid),
        .frag_buf   (frag_buf),
        .frag_idx   (frag_idx),
        .done       (iss_done)
    );

    // Port-facing decodes of the current phase.
    always_comb begin
        is_read       = (state == SEQ_READ);
        buf_ready     = !desc_rd_status;
        desc_rd_en    = is_read;
        desc_rd_idx   = ptr;
        desc_done_en  = (state == SEQ_DONE);
        desc_done_idx = cur_buf;
        irq           = (state == SEQ_DONE);
        capture       = is_read && buf_ready;
    end

    // Next-phase decision, including the fresh / replay / nothing choice.
    always_comb begin
        state_nx  = state;
        replay_nx = replay_q;
        iss_start = 1'b0;
        iss_buf   = ptr;
        iss_cnt   = desc_rd_cnt;
        unique case (state)
            SEQ_IDLE: begin
                if (field_start) state_nx = SEQ_READ;
            end
            SEQ_READ: begin
                if (buf_ready) begin
                    replay_nx = 1'b0;
                    if (desc_rd_cnt == '0) begin
                        state_nx = SEQ_DONE;
                    end else begin
                        iss_start = 1'b1;
                        state_nx  = SEQ_ISSUE;
                    end
                end else if (have_valid && last_cnt != '0) begin
                    replay_nx = 1'b1;
                    iss_start = 1'b1;
                    iss_buf   = last_idx;
                    iss_cnt   = last_cnt;
                    state_nx  = SEQ_ISSUE;
                end else begin
                    state_nx = SEQ_IDLE;
                end
            end
            SEQ_ISSUE: begin
                if (iss_done) state_nx = replay_q ? SEQ_IDLE : SEQ_DONE;
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

    // Phase register, replay flag and the buffer in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            replay_q <= 1'b0;
            cur_buf  <= '0;
        end else begin
            state    <= state_nx;
            replay_q <= replay_nx;
            if (capture) cur_buf <= ptr;
        end
    end

    // Completed-buffer register, loaded at each interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)            irq_buf_idx <= '0;
        else if (desc_done_en) irq_buf_idx <= cur_buf;
    end

    assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done_en |=> (irq_buf_idx == $past(desc_done_idx)));

    assert_replay_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_rd_en && desc_rd_status && have_valid && last_cnt != '0)
            |=> (frag_valid && frag_buf == $past(last_idx) && $stable(ptr)));

    assert_idle_no_hist_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_rd_en && desc_rd_status && !have_valid) |=> (!frag_valid && !desc_done_en));

    assert_one_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({desc_rd_en, frag_valid, desc_done_en}));

    assert_rd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd_en |=> !desc_rd_en);

endmodule

// File: tb/ring_own_seq_bench.sv
// Self-checking bench: a descriptor-memory and host model, a vector table of
// fields walked by one loop, then directed reset and corner-case tests.
module ring_own_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_DESC   = 4;
    localparam int FRAG_W     = 4;
    localparam int IDX_W      = 2;
    localparam int FIELD_WAIT = 48;

    typedef struct packed {
        logic             fill;
        logic [IDX_W-1:0] fidx;
        logic [FRAG_W-1:0] fcnt;
        logic             alt;
        logic [IDX_W-1:0] ebuf;
        logic [4:0]       en;
        logic             eirq;
        logic [IDX_W-1:0] estat;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 4'd0,  1'b0, 2'd0, 5'd0,  1'b0, 2'd0},  // R7 no history
        '{1'b1, 2'd0, 4'd3,  1'b0, 2'd0, 5'd3,  1'b1, 2'd0},  // R3 R4
        '{1'b0, 2'd0, 4'd0,  1'b1, 2'd0, 5'd3,  1'b0, 2'd0},  // R6 replay
        '{1'b1, 2'd1, 4'd5,  1'b1, 2'd1, 5'd5,  1'b1, 2'd1},
        '{1'b1, 2'd2, 4'd1,  1'b0, 2'd2, 5'd1,  1'b1, 2'd2},
        '{1'b1, 2'd3, 4'd2,  1'b1, 2'd3, 5'd2,  1'b1, 2'd3},
        '{1'b1, 2'd0, 4'd4,  1'b0, 2'd0, 5'd4,  1'b1, 2'd0},  // R5 wrap
        '{1'b1, 2'd2, 4'd6,  1'b0, 2'd0, 5'd4,  1'b0, 2'd0},  // R6 no skip
        '{1'b1, 2'd1, 4'd15, 1'b1, 2'd1, 5'd15, 1'b1, 2'd1},
        '{1'b0, 2'd0, 4'd0,  1'b0, 2'd2, 5'd6,  1'b1, 2'd2},
        '{1'b1, 2'd3, 4'd0,  1'b0, 2'd3, 5'd0,  1'b1, 2'd3},  // R9 zero count
        '{1'b0, 2'd0, 4'd0,  1'b0, 2'd3, 5'd0,  1'b0, 2'd3}   // R6 replay of empty
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              field_start = 1'b0;
    logic              desc_rd_en;
    logic [IDX_W-1:0]  desc_rd_idx;
    logic              desc_rd_status;
    logic [FRAG_W-1:0] desc_rd_cnt;
    logic              desc_done_en;
    logic [IDX_W-1:0]  desc_done_idx;
    logic              frag_valid;
    logic              frag_ready;
    logic [IDX_W-1:0]  frag_buf;
    logic [FRAG_W-1:0] frag_idx;
    logic              irq;
    logic [IDX_W-1:0]  irq_buf_idx;

    // Host / memory model controls
    logic              mem_clear = 1'b1;
    logic              fill_req = 1'b0;
    logic [IDX_W-1:0]  fill_idx = '0;
    logic [FRAG_W-1:0] fill_cnt = '0;
    logic              stat_mem [NUM_DESC];
    logic [FRAG_W-1:0] cnt_mem  [NUM_DESC];

    // Ready pattern controls
    logic ready_alt = 1'b0;
    logic ready_low = 1'b0;
    logic ready_tog = 1'b0;

    // Monitor
    logic              mon_clr = 1'b0;
    logic [IDX_W-1:0]  mon_ebuf = '0;
    int                fld_frags, fld_irqs, fld_writes, order_bad;
    logic [IDX_W-1:0]  last_wr_idx;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    ring_own_seq #(.NUM_DESC(NUM_DESC), .FRAG_W(FRAG_W)) u_ring_own_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .field_start    (field_start),
        .desc_rd_en     (desc_rd_en),
        .desc_rd_idx    (desc_rd_idx),
        .desc_rd_status (desc_rd_status),
        .desc_rd_cnt    (desc_rd_cnt),
        .desc_done_en   (desc_done_en),
        .desc_done_idx  (desc_done_idx),
        .frag_valid     (frag_valid),
        .frag_ready     (frag_ready),
        .frag_buf       (frag_buf),
        .frag_idx       (frag_idx),
        .irq            (irq),
        .irq_buf_idx    (irq_buf_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign desc_rd_status = stat_mem[desc_rd_idx];
    assign desc_rd_cnt    = cnt_mem[desc_rd_idx];
    assign frag_ready     = !ready_low && (!ready_alt || ready_tog);

    always @(negedge clk) ready_tog <= ~ready_tog;

    // Descriptor memory: host refills clear the flag, block writes set it.
    always @(posedge clk) begin
        if (mem_clear) begin
            for (int i = 0; i < NUM_DESC; i++) begin
                stat_mem[i] <= 1'b1;
                cnt_mem[i]  <= '0;
            end
        end else begin
            if (fill_req) begin
                stat_mem[fill_idx] <= 1'b0;
                cnt_mem[fill_idx]  <= fill_cnt;
            end
            if (desc_done_en) stat_mem[desc_done_idx] <= 1'b1;
        end
    end

    // Per-field observation of fragments, interrupts and writes.
    always @(posedge clk) begin
        if (mon_clr) begin
            fld_frags  <= 0;
            fld_irqs   <= 0;
            fld_writes <= 0;
            order_bad  <= 0;
        end else if (rst_n) begin
            if (frag_valid && frag_ready) begin
                fld_frags <= fld_frags + 1;
                if (frag_buf != mon_ebuf || int'(frag_idx) != fld_frags)
                    order_bad <= order_bad + 1;
            end
            if (irq) fld_irqs <= fld_irqs + 1;
            if (desc_done_en) begin
                fld_writes  <= fld_writes + 1;
                last_wr_idx <= desc_done_idx;
            end
        end
    end

    task automatic check(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic host_fill(input int idx, input int cnt);
        @(negedge clk);
        fill_req = 1'b1;
        fill_idx = IDX_W'(idx);
        fill_cnt = FRAG_W'(cnt);
        @(negedge clk);
        fill_req = 1'b0;
    endtask

    task automatic start_field(input int ebuf);
        @(negedge clk);
        mon_clr  = 1'b1;
        mon_ebuf = IDX_W'(ebuf);
        @(negedge clk);
        mon_clr     = 1'b0;
        field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
    endtask

    initial begin
        // Reset
        repeat (3) @(negedge clk);
        mem_clear = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!frag_valid, "R1 reset frag_valid", int'(frag_valid), 0);
        check(!irq, "R1 reset irq", int'(irq), 0);
        check(irq_buf_idx == '0, "R1 reset irq_buf_idx", int'(irq_buf_idx), 0);
        check(desc_rd_idx == '0, "R1 reset pointer", int'(desc_rd_idx), 0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            ready_alt = VECS[v].alt;
            if (VECS[v].fill) host_fill(int'(VECS[v].fidx), int'(VECS[v].fcnt));
            start_field(int'(VECS[v].ebuf));
            repeat (FIELD_WAIT) @(negedge clk);
            check(fld_frags == int'(VECS[v].en), $sformatf("R3/R6 vec%0d fragment count", v),
                  fld_frags, int'(VECS[v].en));
            check(order_bad == 0, $sformatf("R3 vec%0d fragment order/buffer", v), order_bad, 0);
            check(fld_irqs == int'(VECS[v].eirq), $sformatf("R4 vec%0d interrupt count", v),
                  fld_irqs, int'(VECS[v].eirq));
            check(fld_writes == int'(VECS[v].eirq), $sformatf("R4 vec%0d write count", v),
                  fld_writes, int'(VECS[v].eirq));
            check(irq_buf_idx == VECS[v].estat, $sformatf("R4 vec%0d irq_buf_idx", v),
                  int'(irq_buf_idx), int'(VECS[v].estat));
            if (VECS[v].eirq)
                check(last_wr_idx == VECS[v].ebuf, $sformatf("R4 vec%0d written index", v),
                      int'(last_wr_idx), int'(VECS[v].ebuf));
        end
        ready_alt = 1'b0;

        // Pointer is back at 0 (R5): read strobe and index, stall, stray field start
        host_fill(0, 8);
        ready_low = 1'b1;
        start_field(0);
        check(desc_rd_en, "R2 read strobe after field start", int'(desc_rd_en), 1);
        check(desc_rd_idx == 2'd0, "R2 R5 read index after wrap", int'(desc_rd_idx), 0);
        @(negedge clk);
        check(!desc_rd_en, "R2 read strobe single cycle", int'(desc_rd_en), 0);
        check(frag_valid && frag_idx == '0, "R3 first fragment offered", int'(frag_idx), 0);
        repeat (5) @(negedge clk);
        check(frag_valid && frag_idx == '0, "R3 fragment held while not ready", int'(frag_idx), 0);
        field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
        ready_low = 1'b0;
        repeat (FIELD_WAIT) @(negedge clk);
        check(fld_frags == 8, "R8 stray field start: fragment count", fld_frags, 8);
        check(fld_irqs == 1, "R8 stray field start: interrupt count", fld_irqs, 1);
        check(order_bad == 0, "R8 stray field start: order", order_bad, 0);
        check(desc_rd_idx == 2'd1, "R4 pointer advanced", int'(desc_rd_idx), 1);

        // Mid-transfer reset clears outputs and history
        host_fill(1, 6);
        ready_low = 1'b1;
        start_field(1);
        @(negedge clk);
        rst_n = 1'b0;
        mem_clear = 1'b1;
        repeat (2) @(negedge clk);
        check(!frag_valid, "R1 mid reset frag_valid", int'(frag_valid), 0);
        check(irq_buf_idx == '0, "R1 mid reset irq_buf_idx", int'(irq_buf_idx), 0);
        check(desc_rd_idx == '0, "R1 mid reset pointer", int'(desc_rd_idx), 0);
        rst_n = 1'b1;
        mem_clear = 1'b0;
        ready_low = 1'b0;
        start_field(0);
        repeat (FIELD_WAIT) @(negedge clk);
        check(fld_frags == 0, "R7 R1 history cleared: fragments", fld_frags, 0);
        check(fld_writes == 0, "R7 history cleared: writes", fld_writes, 0);
        host_fill(0, 2);
        start_field(0);
        repeat (FIELD_WAIT) @(negedge clk);
        check(fld_frags == 2 && order_bad == 0, "R1 R3 first field after reset", fld_frags, 2);
        check(fld_irqs == 1, "R4 first field after reset interrupt", fld_irqs, 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule